// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of a single SDRAM read or write burst. A column command is presented as a one-cycle start strobe together with the starting column, a three-bit length code and an order bit. From the next clock on, the block presents one column per cycle with a valid flag and marks the final beat with a last flag. Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned block of the row, in either linear (sequential) or bit-flipped (interleaved) order. A full-row burst steps through all 512 columns of the row, wraps around, and keeps going until it is stopped.

A stop strobe ends any burst on the beat that is showing. A fresh start strobe during a burst cuts the old burst short, and the new burst's first beat appears on the very next clock. This allows back-to-back column commands one clock apart. The controller uses `valid_o`/`col_o` to drive the address pins and `last_o` to schedule what follows. Length codes with no defined burst still produce a one-beat burst, and they raise a flag.

The control is a three-state machine. IDLE: no beat is shown. FIXED: a burst of 1 to 8 beats runs. PAGE: a full-row burst runs. The transitions are:
- start (IDLE, FIXED or PAGE, into FIXED or PAGE according to the code)
- stop (FIXED or PAGE into IDLE)
- end-of-count (FIXED into IDLE after beat BL-1)
- advance (stay in FIXED or PAGE, beat counter plus one)

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset `valid_o`, `last_o` and `bad_len_o` are 0.
- R2: In the cycle after a clock with `start_i`=1, `valid_o`=1 and `col_o` equals the sampled `start_col_i` (beat 0).
- R3: In sequential order (`ilv_i`=0) with a fixed length BL, beat i shows the start column with its low log2(BL) bits replaced by (start low bits + i) mod BL. The upper bits do not change.
- R4: In interleaved order (`ilv_i`=1) with a fixed length BL, beat i shows the start column with its low log2(BL) bits XORed with i.
- R5: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. With no stop and no new start, `valid_o` is 0 in the cycle after the last beat.
- R6: Length code 7 selects a full-row burst. Beat i shows (start + i) mod 512, and `ilv_i` has no effect. The burst continues past 512 beats until stopped.
- R7: Length codes 4, 5 and 6 run as a one-beat burst with `bad_len_o`=1. `bad_len_o` follows the code of the most recent start, so a legal code clears it from the new burst's first beat on.
- R8: `last_o` is 1 on beat BL-1 of a fixed burst. In a full-row burst it is 1 only in a cycle where `stop_i` is 1.
- R9: `stop_i`=1 while `valid_o`=1 makes the beat shown the final one (`last_o`=1). Without a start in that cycle, `valid_o` is 0 in the next cycle.
- R10: `start_i` during a burst makes the next cycle show beat 0 of the new burst. When `start_i` and `stop_i` are both 1, the start takes priority.
- R11: `stop_i` while no burst is running has no effect: `valid_o` and `last_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command strobe, starts a burst |
| stop_i | input | 1 | Burst stop strobe |
| start_col_i | input | 9 | Starting column of the burst |
| len_code_i | input | 3 | Burst length code (0..3 fixed, 7 full row, 4..6 undefined) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| col_o | output | 9 | Column for the current beat |
| valid_o | output | 1 | A beat is shown this cycle |
| last_o | output | 1 | The current beat is the final one |
| bad_len_o | output | 1 | The current burst was started with an undefined length code |

## Verification
A stop and a new column command can arrive in the same cycle, on a beat of a running burst. The bench provokes this by raising `stop_i` and `start_i` together in the middle of an eight-beat burst. It then checks three things: the old beat is flagged last in that cycle, the next cycle shows the new start column rather than going idle, and the new burst then runs its full length. Stop is also applied on its own to a fixed burst, to a full-row burst after it has wrapped, and while idle, so that each path can be seen separately.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } colgen_state_t;

    localparam int          LEN_W    = 3;
    localparam logic [2:0]  LEN_BL1  = 3'd0;
    localparam logic [2:0]  LEN_BL2  = 3'd1;
    localparam logic [2:0]  LEN_BL4  = 3'd2;
    localparam logic [2:0]  LEN_BL8  = 3'd3;
    localparam logic [2:0]  LEN_ROW  = 3'd7;

endpackage

// File: rtl/colgen_len_dec.sv
// Maps the length code to a low-bit wrap mask, a full-row flag and an
// undefined-code flag. Undefined codes fall back to a one-beat burst.
module colgen_len_dec
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_W-1:0] code_i,
    output logic [COL_W-1:0] mask_o,
    output logic             row_o,
    output logic             bad_o
);

    always_comb begin
        mask_o = '0;
        row_o  = 1'b0;
        bad_o  = 1'b0;
        unique case (code_i)
            LEN_BL1: mask_o = COL_W'(0);
            LEN_BL2: mask_o = COL_W'(1);
            LEN_BL4: mask_o = COL_W'(3);
            LEN_BL8: mask_o = COL_W'(7);
            LEN_ROW: begin
                mask_o = '1;
                row_o  = 1'b1;
            end
            default: bad_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/colgen_addr_map.sv
// Forms the beat's column from the base column and beat index.
// Bits inside the mask wrap (linear add or XOR), bits outside stay put.
module colgen_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    input  logic             row_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] flip_sum;

    assign lin_sum  = base_i + beat_i;
    assign flip_sum = base_i ^ beat_i;

    for (genvar g = 0; g < COL_W; g++) begin : g_bit
        assign col_o[g] = row_i     ? lin_sum[g] :
                          mask_i[g] ? (ilv_i ? flip_sum[g] : lin_sum[g]) :
                                      base_i[g];
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             bad_len_o
);

    localparam logic [COL_W-1:0] BEAT_ONE = COL_W'(1);

    colgen_state_t    state_q, state_d;
    logic [COL_W-1:0] beat_q, beat_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic             ilv_q, ilv_d;
    logic             bad_q, bad_d;

    logic [COL_W-1:0] dec_mask;
    logic             dec_row;
    logic             dec_bad;
    logic             at_end;

    colgen_len_dec #(.COL_W(COL_W)) u_len_dec (
        .code_i (len_code_i),
        .mask_o (dec_mask),
        .row_o  (dec_row),
        .bad_o  (dec_bad)
    );

    colgen_addr_map #(.COL_W(COL_W)) u_addr_map (
        .base_i (base_q),
        .beat_i (beat_q),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .row_i  (state_q == ST_PAGE),
        .col_o  (col_o)
    );

    assign at_end = (beat_q == mask_q);

    // next-state and load logic
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        base_d  = base_q;
        mask_d  = mask_q;
        ilv_d   = ilv_q;
        bad_d   = bad_q;
        if (start_i) begin
            state_d = dec_row ? ST_PAGE : ST_FIXED;
            beat_d  = '0;
            base_d  = start_col_i;
            mask_d  = dec_mask;
            ilv_d   = ilv_i & ~dec_row;
            bad_d   = dec_bad;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_FIXED: begin
                    if (stop_i || at_end) state_d = ST_IDLE;
                    else                  beat_d  = beat_q + BEAT_ONE;
                end
                ST_PAGE: begin
                    if (stop_i) state_d = ST_IDLE;
                    else        beat_d  = beat_q + BEAT_ONE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            base_q  <= base_d;
            mask_q  <= mask_d;
            ilv_q   <= ilv_d;
            bad_q   <= bad_d;
        end
    end

    // outputs
    always_comb begin
        valid_o   = 1'b0;
        last_o    = 1'b0;
        bad_len_o = bad_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_FIXED: begin
                valid_o = 1'b1;
                last_o  = at_end | stop_i;
            end
            ST_PAGE: begin
                valid_o = 1'b1;
                last_o  = stop_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    // R2
    start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R9
    stop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stop_i) |-> last_o);

    // R9
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    // R8
    last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_o && !start_i) |=> !valid_o);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o);

    // R11
    idle_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !last_o);

endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_colgen_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;
    logic       bad_len_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdram_burst_colgen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .start_col_i(start_col_i), .len_code_i(len_code_i), .ilv_i(ilv_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .bad_len_o(bad_len_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int base, input int i, input int bl,
                                   input bit ilv, input bit row);
        int m;
        if (row) return (base + i) & 9'h1FF;
        m = bl - 1;
        if (ilv) return (base & ~m & 9'h1FF) | ((base ^ i) & m);
        return (base & ~m & 9'h1FF) | ((base + i) & m);
    endfunction

    // issue a start; returns at the negedge where beat 0 is visible
    task automatic go(input int col, input int code, input bit ilv);
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'(col); len_code_i = 3'(code); ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 valid", valid_o, 0);
        chk("R1 last", last_o, 0);
        chk("R1 bad_len", bad_len_o, 0);
    endtask

    task automatic t_fixed(input int col, input int code, input bit ilv, input string req);
        int bl = 1 << code;
        go(col, code, ilv);
        chk("R2 first col", col_o, col);
        chk("R7 bad_len clear", bad_len_o, 0);
        for (int i = 0; i < bl; i++) begin
            chk({req, " col"}, col_o, exp_col(col, i, bl, ilv, 0));
            chk("R5 valid", valid_o, 1);
            chk("R8 last", last_o, (i == bl - 1) ? 1 : 0);
            @(negedge clk); #1;
        end
        chk("R5 idle after burst", valid_o, 0);
    endtask

    task automatic t_reserved();
        go(9'h0AB, 5, 0);
        chk("R7 bad_len set", bad_len_o, 1);
        chk("R7 col", col_o, 9'h0AB);
        chk("R7 one beat last", last_o, 1);
        @(negedge clk); #1;
        chk("R7 one beat end", valid_o, 0);
        t_fixed(9'h011, 1, 0, "R7 recover");
    endtask

    task automatic t_page();
        int base = 9'h1FD;
        go(base, 7, 1);
        for (int i = 0; i < 600; i++) begin
            if (col_o != 9'(exp_col(base, i, 512, 1, 1)) || last_o || !valid_o) begin
                chk("R6 row col", col_o, exp_col(base, i, 512, 1, 1));
                chk("R8 row last", last_o, 0);
            end
            @(negedge clk); #1;
        end
        chk("R6 row col after wrap", col_o, exp_col(base, 600, 512, 1, 1));
        chk("R8 row no last", last_o, 0);
        stop_i = 1'b1; #1;
        chk("R9 row stop last", last_o, 1);
        @(negedge clk); stop_i = 1'b0; #1;
        chk("R9 row stop idle", valid_o, 0);
    endtask

    task automatic t_stop_fixed();
        go(9'h040, 3, 0);
        @(negedge clk); @(negedge clk);
        stop_i = 1'b1; #1;
        chk("R9 stop col", col_o, 9'h042);
        chk("R9 stop last", last_o, 1);
        @(negedge clk); stop_i = 1'b0; #1;
        chk("R9 stop idle", valid_o, 0);
    endtask

    task automatic t_interrupt();
        go(9'h120, 3, 0);
        @(negedge clk); @(negedge clk); @(negedge clk);
        start_i = 1'b1; stop_i = 1'b1; start_col_i = 9'h0E6; len_code_i = 3'd2; ilv_i = 1'b1;
        #1;
        chk("R10 old beat col", col_o, 9'h123);
        chk("R10 stop marks last", last_o, 1);
        @(negedge clk); start_i = 1'b0; stop_i = 1'b0; #1;
        for (int i = 0; i < 4; i++) begin
            chk("R10 new burst valid", valid_o, 1);
            chk("R10 new burst col", col_o, exp_col(9'h0E6, i, 4, 1, 0));
            chk("R10 new burst last", last_o, (i == 3) ? 1 : 0);
            @(negedge clk); #1;
        end
        chk("R10 new burst end", valid_o, 0);
    endtask

    task automatic t_idle_stop();
        @(negedge clk);
        stop_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R11 idle valid", valid_o, 0);
            chk("R11 idle last", last_o, 0);
            @(negedge clk);
        end
        stop_i = 1'b0; #1;
        chk("R11 idle after", valid_o, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_fixed(9'h1F5, 3, 0, "R3 seq bl8");
        t_fixed(9'h0A6, 2, 1, "R4 ilv bl4");
        t_fixed(9'h133, 3, 1, "R4 ilv bl8");
        t_fixed(9'h0FF, 1, 0, "R3 seq bl2");
        t_fixed(9'h07D, 0, 1, "R5 bl1");
        t_reserved();
        t_page();
        t_stop_fixed();
        t_interrupt();
        t_idle_stop();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule